// File: doc/BRIEF.md
# Dual-Channel FIFO PCM Player

This block plays 8-bit unsigned sample streams on two independent channels. The processor sees it as a small bank of write registers and reads back one status byte per channel. Each channel has a 256-entry sample queue, a 12-bit reload timer that counts processor clock cycles, and a 4-bit volume. The timer sets how long each sample is held. The block produces a signed, volume-scaled sample value per channel. Mixing the two channels and converting to analog are done outside the block.

Playback starts and stops without any command. A byte written to a silent channel sounds on the next cycle. Bytes written while the channel sounds wait in the queue and play in the order they were written. When a sample ends and the queue is empty, the channel falls silent. A new period applies only from the next sample boundary. A new volume scales the current output at once.

Top module: `pcm_duo`

## Requirements
- R1: The write address selects the channel with bit 2 (0 or 1) and the function with bits 1:0: 0 = clear, 1 = sample data, 2 = period bits 7:0, 3 = period bits 11:8 from data bits 3:0 together with volume from data bits 7:4. A write to one channel leaves the other channel's output and status unchanged.
- R2: Each channel's status byte has bit 7 = queue full (256 bytes held), bit 6 = queue empty, and bits 5:0 = 0. After reset both status bytes read 0x40 and both outputs are 0.
- R3: A data write to a silent channel, whose queue is then always empty, puts that byte on the output from the next cycle and loads the timer from the current period.
- R4: Every sample stays on the output for period + 1 cycles. Queued bytes follow one another with no gap, in write order.
- R5: When a sample ends and the queue is empty, the output becomes 0 in the cycle where the next sample would have started. It stays 0 until the next data write.
- R6: The output is (byte - 128) x volume as a 12-bit two's-complement value, so it ranges from -1920 to +1905.
- R7: A period write does not change the length of the sample that is playing. The new value takes effect from the next sample on.
- R8: A volume write changes the output on the next cycle, in the middle of a sample.
- R9: A clear write empties the queue and makes the output 0 on the next cycle. The channel stays silent until a later data write, which starts playback afresh as in R3.
- R10: The queue holds 256 bytes. A data write while it is full is discarded and never played.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; also the timer tick |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 3 | Register offset: bit 2 channel, bits 1:0 function |
| wr_data | input | 8 | Write data |
| stat0 | output | 8 | Channel 0 status: bit 7 full, bit 6 empty |
| stat1 | output | 8 | Channel 1 status: bit 7 full, bit 6 empty |
| out0 | output | 12 | Channel 0 scaled sample, two's complement |
| out1 | output | 12 | Channel 1 scaled sample, two's complement |

## Verification
The properties assume that `wr_addr` and `wr_data` are valid whenever `wr_en` is high. They also assume that reset is held across at least one rising edge before the first write. A single address port means at most one register write per cycle, so a clear and a data write can never reach the same channel together. The bench changes all inputs only on falling edges and drops `wr_en` outside its write tasks. Because of this, every write the properties see is one the bench intended.

// File: rtl/pcm_duo_pkg.sv
package pcm_duo_pkg;
  localparam int DATA_W  = 8;
  localparam int PER_W   = 12;
  localparam int VOL_W   = 4;
  localparam int FIFO_AW = 8;
  localparam int OUT_W   = DATA_W + VOL_W;

  typedef enum logic [1:0] {
    FN_CLEAR  = 2'd0,
    FN_DATA   = 2'd1,
    FN_PER_LO = 2'd2,
    FN_PER_HI = 2'd3
  } fn_e;
endpackage

// File: rtl/pcm_fifo.sv
module pcm_fifo #(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;

  // storage and registered read port kept free of reset for RAM inference
  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (do_pop) rdata <= mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/pcm_chan.sv
module pcm_chan #(
  parameter int DATA_W  = 8,
  parameter int PER_W   = 12,
  parameter int VOL_W   = 4,
  parameter int FIFO_AW = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_clr,
  input  logic                      wr_dat,
  input  logic                      wr_plo,
  input  logic                      wr_phi,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         status,
  output logic [DATA_W+VOL_W-1:0]   out,
  output logic                      busy
);
  localparam int OUT_W = DATA_W + VOL_W;
  localparam int PHI_W = PER_W - DATA_W;

  logic [PER_W-1:0]  per_q, per_d, tmr_q, tmr_d;
  logic [VOL_W-1:0]  vol_q, vol_d;
  logic [DATA_W-1:0] hold_q, hold_d, samp_q, samp_d, f_rdata;
  logic              play_q, play_d, snd_q, snd_d;
  logic              pend_q, pend_d, dry_q, dry_d, dir_q, dir_d;
  logic              f_empty, f_full;
  logic              expire, direct, push, pop;
  logic signed [OUT_W-1:0] cen_x, vol_x, prod;
  logic [OUT_W-1:0]  out_q, out_d;

  // a sample boundary: timer exhausted, unless a silence is already resolving
  assign expire = play_q && (tmr_q == '0) && !(pend_q && dry_q);
  // a byte bypasses the queue when nothing is (or will stay) sounding
  assign direct = wr_dat && f_empty && (!play_q || expire || (pend_q && dry_q));
  assign push   = wr_dat && !direct;
  assign pop    = expire && !f_empty;

  pcm_fifo #(.W(DATA_W), .AW(FIFO_AW)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .clr   (wr_clr),
    .push  (push),
    .wdata (wdata),
    .pop   (pop),
    .rdata (f_rdata),
    .empty (f_empty),
    .full  (f_full)
  );

  always_comb begin
    per_d  = per_q;
    vol_d  = vol_q;
    tmr_d  = tmr_q;
    play_d = play_q;
    snd_d  = snd_q;
    pend_d = 1'b0;
    dry_d  = dry_q;
    dir_d  = dir_q;
    hold_d = hold_q;
    samp_d = samp_q;

    if (wr_plo) per_d[DATA_W-1:0] = wdata;
    if (wr_phi) begin
      per_d[PER_W-1:DATA_W] = wdata[PHI_W-1:0];
      vol_d                 = wdata[DATA_W-1 -: VOL_W];
    end

    // resolve the boundary issued last cycle
    if (pend_q) begin
      if (dir_q) begin
        samp_d = hold_q;
        snd_d  = 1'b1;
      end else if (!dry_q) begin
        samp_d = f_rdata;
        snd_d  = 1'b1;
      end else begin
        play_d = 1'b0;
        snd_d  = 1'b0;
      end
    end

    if (play_q && (tmr_q != '0)) tmr_d = tmr_q - 1'b1;

    if (direct) begin
      hold_d = wdata;
      play_d = 1'b1;
      tmr_d  = per_q;
      pend_d = 1'b1;
      dir_d  = 1'b1;
      dry_d  = 1'b0;
    end else if (expire) begin
      tmr_d  = per_q;
      pend_d = 1'b1;
      dir_d  = 1'b0;
      dry_d  = f_empty;
    end

    if (wr_clr) begin
      play_d = 1'b0;
      snd_d  = 1'b0;
      pend_d = 1'b0;
      tmr_d  = per_q;
    end
  end

  // offset-binary to two's complement: flip the top bit
  always_comb begin
    cen_x = {{VOL_W{~samp_d[DATA_W-1]}}, ~samp_d[DATA_W-1], samp_d[DATA_W-2:0]};
    vol_x = {{DATA_W{1'b0}}, vol_d};
    prod  = cen_x * vol_x;
    out_d = snd_d ? prod : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q  <= '0;
      vol_q  <= '0;
      tmr_q  <= '0;
      play_q <= 1'b0;
      snd_q  <= 1'b0;
      pend_q <= 1'b0;
      dry_q  <= 1'b0;
      dir_q  <= 1'b0;
      hold_q <= '0;
      samp_q <= '0;
      out_q  <= '0;
    end else begin
      per_q  <= per_d;
      vol_q  <= vol_d;
      tmr_q  <= tmr_d;
      play_q <= play_d;
      snd_q  <= snd_d;
      pend_q <= pend_d;
      dry_q  <= dry_d;
      dir_q  <= dir_d;
      hold_q <= hold_d;
      samp_q <= samp_d;
      out_q  <= out_d;
    end
  end

  assign out    = out_q;
  assign busy   = play_q;
  assign status = {f_full, f_empty, {(DATA_W-2){1'b0}}};
endmodule

// File: rtl/pcm_duo.sv
module pcm_duo
  import pcm_duo_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int PW  = PER_W,
  parameter int VW  = VOL_W,
  parameter int QAW = FIFO_AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    stat0,
  output logic [DW-1:0]    stat1,
  output logic [DW+VW-1:0] out0,
  output logic [DW+VW-1:0] out1
);
  localparam int NCH = 2;
  localparam int OW  = DW + VW;

  fn_e            fn;
  logic [DW-1:0]  stat_a [NCH];
  logic [OW-1:0]  out_a  [NCH];
  logic [NCH-1:0] busy;

  assign fn = fn_e'(wr_addr[1:0]);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel = wr_en && (wr_addr[2] == 1'(c));

    pcm_chan #(.DATA_W(DW), .PER_W(PW), .VOL_W(VW), .FIFO_AW(QAW)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .wr_clr (sel && (fn == FN_CLEAR)),
      .wr_dat (sel && (fn == FN_DATA)),
      .wr_plo (sel && (fn == FN_PER_LO)),
      .wr_phi (sel && (fn == FN_PER_HI)),
      .wdata  (wr_data),
      .status (stat_a[c]),
      .out    (out_a[c]),
      .busy   (busy[c])
    );
  end

  assign stat0 = stat_a[0];
  assign stat1 = stat_a[1];
  assign out0  = out_a[0];
  assign out1  = out_a[1];
endmodule

// File: rtl/pcm_duo_chk.sv
module pcm_duo_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [7:0]  wr_data,
  input logic [7:0]  stat0,
  input logic [7:0]  stat1,
  input logic [11:0] out0,
  input logic [11:0] out1,
  input logic [1:0]  busy
);
  AST_CLEAR_SILENCES_CH0: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_addr == 3'd0 |=> out0 == 12'd0 && stat0 == 8'h40); // R9
  AST_CLEAR_SILENCES_CH1: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_addr == 3'd4 |=> out1 == 12'd0 && stat1 == 8'h40); // R9
  AST_STATUS_SHAPE_CH0: assert property (@(posedge clk) disable iff (rst)
    stat0[5:0] == 6'd0 && !(stat0[7] && stat0[6])); // R2
  AST_STATUS_SHAPE_CH1: assert property (@(posedge clk) disable iff (rst)
    stat1[5:0] == 6'd0 && !(stat1[7] && stat1[6])); // R2
  AST_ZERO_VOL_MUTES: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_addr == 3'd3 && wr_data[7:4] == 4'd0 |=> out0 == 12'd0); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy[0] |-> out0 == 12'd0 && stat0[6]); // R5
  AST_START_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_addr == 3'd5 && !busy[1] |=> busy[1]); // R3
  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (rst)
    $signed(out1) >= -12'sd1920 && $signed(out1) <= 12'sd1905); // R6
endmodule

bind pcm_duo pcm_duo_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .stat0(stat0), .stat1(stat1), .out0(out0), .out1(out1), .busy(busy)
);

// File: tb/pcm_duo_tb.sv
`timescale 1ns/1ps
module pcm_duo_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [7:0]  stat0, stat1;
  logic [11:0] out0, out1;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done  = 1'b0;

  always #2.5 clk = ~clk;

  pcm_duo u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stat0(stat0), .stat1(stat1), .out0(out0), .out1(out1)
  );

  // {sample byte, volume, expected output}
  localparam logic [23:0] VEC [8] = '{
    {8'h80, 4'd5,  12'd0},
    {8'hFF, 4'd15, 12'd1905},
    {8'h00, 4'd15, -12'sd1920},
    {8'h81, 4'd1,  12'd1},
    {8'h7F, 4'd3,  -12'sd3},
    {8'hC0, 4'd8,  12'd512},
    {8'h40, 4'd2,  -12'sd128},
    {8'hA5, 4'd0,  12'd0}
  };

  function automatic int s12(input logic [11:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called on a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int seq_exp(input int t);
    if (t <= 4)  return 16;
    if (t <= 8)  return 32;
    if (t <= 12) return 48;
    return 0;
  endfunction

  function automatic int per_exp(input int t);
    if (t <= 6)  return 2;
    if (t <= 12) return 3;
    return 0;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int waited;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R2 reset state
    chk("R2 stat0 reset", stat0, 8'h40);
    chk("R2 stat1 reset", stat1, 8'h40);
    chk("R2 out0 reset", s12(out0), 0);
    chk("R2 out1 reset", s12(out1), 0);

    // R6 / R3 table: byte starts an idle channel, scaled output next cycle
    for (int i = 0; i < 8; i++) begin
      wr(3'd0, 8'h00);
      wr(3'd3, {VEC[i][15:12], 4'hF});
      wr(3'd2, 8'hFF);
      wr(3'd1, VEC[i][23:16]);
      chk("R3 not yet audible", s12(out0), 0);
      idle(1);
      chk("R6 scaled sample", s12(out0), s12(VEC[i][11:0]));
    end

    // R4 / R5 on channel 1, period 3, volume 1
    wr(3'd4, 8'h00);
    wr(3'd7, 8'h10);
    wr(3'd6, 8'h03);
    wr(3'd5, 8'h90);
    wr(3'd5, 8'hA0);
    wr(3'd5, 8'hB0);
    for (int t = 2; t <= 16; t++) begin
      chk((t <= 12) ? "R4 sample order/length" : "R5 silence when dry", s12(out1), seq_exp(t));
      @(negedge clk);
    end
    idle(20);
    chk("R5 stays silent", s12(out1), 0);
    chk("R5 queue empty", stat1, 8'h40);
    chk("R1 channel 0 untouched", s12(out0), 0);

    // R7: period change mid-sample on channel 0
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h10);
    wr(3'd2, 8'h02);
    wr(3'd1, 8'h81);
    wr(3'd1, 8'h82);
    wr(3'd1, 8'h83);
    idle(1);
    wr(3'd2, 8'h05);
    for (int t = 4; t <= 14; t++) begin
      chk("R7 period applies next sample", s12(out0), per_exp(t));
      @(negedge clk);
    end

    // R8: volume applies at once
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h1F);
    wr(3'd2, 8'hFF);
    wr(3'd1, 8'h90);
    idle(1);
    chk("R8 base volume", s12(out0), 16);
    wr(3'd3, 8'h3F);
    chk("R8 volume 3 at once", s12(out0), 48);
    wr(3'd3, 8'h0F);
    chk("R8 volume 0 at once", s12(out0), 0);
    wr(3'd3, 8'hFF);
    chk("R8 volume 15 at once", s12(out0), 240);

    // R9: clear while playing with queued data
    wr(3'd1, 8'h10);
    wr(3'd1, 8'h20);
    chk("R2 partly filled", stat0, 8'h00);
    wr(3'd0, 8'h00);
    chk("R9 clear silences", s12(out0), 0);
    chk("R9 clear empties", stat0, 8'h40);
    idle(10);
    chk("R9 remains silent", s12(out0), 0);
    wr(3'd1, 8'h88);
    idle(1);
    chk("R9 restart after clear", s12(out0), 120);
    wr(3'd0, 8'h00);

    // R10: fill channel 1, overflow byte dropped
    wr(3'd4, 8'h00);
    wr(3'd7, 8'h1F);
    wr(3'd6, 8'hFF);
    wr(3'd5, 8'h81);
    for (int k = 0; k < 256; k++) wr(3'd5, 8'(k));
    chk("R10 queue full", stat1, 8'h80);
    wr(3'd5, 8'hFF);
    chk("R10 still full", stat1, 8'h80);
    chk("R1 channel 0 unaffected", s12(out0), 0);
    wr(3'd6, 8'h00);
    wr(3'd7, 8'h10);
    waited = 0;
    while (s12(out1) != -128 && waited < 6000) begin
      @(negedge clk);
      waited++;
    end
    for (int k = 0; k < 256; k++) begin
      chk("R10 drained in order", s12(out1), k - 128);
      @(negedge clk);
    end
    chk("R10 overflow byte not played", s12(out1), 0);
    chk("R10 drained empty", stat1, 8'h40);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule